// File: doc/BRIEF.md
# Overlapping-Fan-In Rule Combiner

This block turns a pool of functional-unit match bits into rule outputs for a pattern classifier. Each rule is an AND gate, and neighbouring gates overlap: every unit is physically wired to up to three gates. A per-link enable bit either admits that unit into a gate or blocks it, and a blocked link counts as logic 1 at the AND. The number of units a rule combines is therefore chosen at run time rather than fixed when the logic is built. A gate with every link blocked is treated as an empty rule and never fires.

Configuration is held in a register of three enable bits per unit. The register is written one unit at a time through a valid/address/data port. The rule-fire vector and the number of rules firing are registered one clock after the unit bits are presented. When an exclusive-assignment flag is raised, which is the setting used while one gate at a time is being tuned, the block raises an error bit if any unit is enabled on more than one existing gate.

Top module: `flexrule_combiner`

## Requirements
- R1: After a synchronous active-high reset, every link enable is cleared and `rule_fire`, `rule_count` and `excl_err` are 0.
- R2: With G = NUM_UNITS/2 gates, unit i is wired to gates i/2-1, i/2 and i/2+1 (integer division), but only to those numbered 0 to G-1. In a unit's 3-bit mask, bit 0 enables the link to gate i/2-1, bit 1 the link to gate i/2, and bit 2 the link to gate i/2+1. A bit whose gate does not exist has no effect on any output.
- R3: A gate fires exactly when at least one of its links is enabled and every unit on an enabled link is 1. The values of units on blocked links do not matter.
- R4: A gate with no enabled link outputs 0 for any unit values.
- R5: When `cfg_we` is 1 at a clock edge, `cfg_mask` replaces the mask of unit `cfg_addr`. The new mask first applies at the following edge; the evaluation made at the write edge still uses the old mask.
- R6: `rule_fire` (bit g for gate g) and `rule_count` present, one cycle later, the evaluation of the `unit_bits` sampled at a clock edge. `rule_count` equals the number of set bits in `rule_fire`.
- R7: `excl_err` is registered at each edge. It is 1 when `excl_mode` was 1 and some unit had more than one enabled link to an existing gate, and 0 otherwise. Enable bits on links to gates that do not exist are not counted.
- R8: A unit enabled on several gates takes part in all of them in the same evaluation, so overlapping rules may combine different numbers of units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_bits | input | NUM_UNITS | Functional-unit match bits |
| cfg_we | input | 1 | Mask write valid |
| cfg_addr | input | $clog2(NUM_UNITS) | Unit whose mask is written |
| cfg_mask | input | 3 | Link enables: bit0 lower gate, bit1 own gate, bit2 upper gate |
| excl_mode | input | 1 | Exclusive-assignment check enable |
| rule_fire | output | NUM_UNITS/2 | Registered rule-fire bits |
| rule_count | output | $clog2(NUM_UNITS/2+1) | Registered number of rules firing |
| excl_err | output | 1 | Registered exclusive-assignment violation |

## Verification
A mask write and a rule evaluation can fall on the same clock edge. In that case the evaluation, and the exclusive check, must use the mask from before the write. The bench provokes this by changing a unit's mask at the same edge that presents unit bits which would fire under one mask and stay quiet under the other. It does the same with writes that create and remove a double assignment while `excl_mode` is high. The outputs are judged against a reference model that updates its own mask copy only after it has evaluated that edge, and the comparison is made on every clock.

// File: rtl/flexrule_pkg.sv
package flexrule_pkg;

    localparam int DEF_UNITS = 16;
    localparam int LINKS     = 3;

    // Per-unit link enables; lower = gate i/2-1, own = i/2, upper = i/2+1
    typedef struct packed {
        logic upper;
        logic own;
        logic lower;
    } link_mask_t;

    // Accumulator for one AND gate
    typedef struct packed {
        logic any_on;
        logic all_one;
    } gate_acc_t;

    function automatic int link_gate(input int unit, input int slot);
        return unit / 2 + slot - 1;
    endfunction

    function automatic logic link_exists(input int unit, input int slot, input int gates);
        int g;
        g = link_gate(unit, slot);
        return (g >= 0) && (g < gates);
    endfunction

    function automatic logic link_on(input link_mask_t m, input int slot);
        logic r;
        case (slot)
            0:       r = m.lower;
            1:       r = m.own;
            default: r = m.upper;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flexrule_mask_bank.sv
module flexrule_mask_bank
    import flexrule_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS,
    parameter int ADDR_W    = $clog2(NUM_UNITS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  link_mask_t                      wr_data,
    output link_mask_t [NUM_UNITS-1:0]      masks_o
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst)
                masks_o[u] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(u)))
                masks_o[u] <= wr_data;
        end
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (masks_o[$past(wr_addr)] == $past(wr_data))); // R5

endmodule

// File: rtl/flexrule_gate_array.sv
module flexrule_gate_array
    import flexrule_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS,
    parameter int NUM_GATES = NUM_UNITS / 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_UNITS-1:0]            unit_bits,
    input  link_mask_t [NUM_UNITS-1:0]      masks,
    output logic [NUM_GATES-1:0]            fire_c
);

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        gate_acc_t acc;
        always_comb begin
            acc.any_on  = 1'b0;
            acc.all_one = 1'b1;
            for (int i = 0; i < NUM_UNITS; i++) begin
                for (int s = 0; s < LINKS; s++) begin
                    if ((link_gate(i, s) == g) && link_on(masks[i], s)) begin
                        acc.any_on  = 1'b1;
                        acc.all_one = acc.all_one & unit_bits[i];
                    end
                end
            end
            // an empty rule never fires
            fire_c[g] = acc.any_on & acc.all_one;
        end
    end

    AST_ZERO_UNITS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (unit_bits == '0) |-> (fire_c == '0)); // R3

    AST_EMPTY_NEVER_FIRES: assert property (@(posedge clk) disable iff (rst)
        (masks == '0) |-> (fire_c == '0)); // R4

endmodule

// File: rtl/flexrule_excl_check.sv
module flexrule_excl_check
    import flexrule_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS,
    parameter int NUM_GATES = NUM_UNITS / 2
) (
    input  link_mask_t [NUM_UNITS-1:0]      masks,
    input  logic                            excl_mode,
    output logic                            conflict_o
);

    logic [NUM_UNITS-1:0] multi;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [1:0] links_on;
        always_comb begin
            links_on = '0;
            for (int s = 0; s < LINKS; s++) begin
                if (link_exists(u, s, NUM_GATES) && link_on(masks[u], s))
                    links_on = links_on + 2'd1;
            end
            multi[u] = (links_on > 2'd1);
        end
    end

    assign conflict_o = excl_mode & (|multi);

endmodule

// File: rtl/flexrule_combiner.sv
module flexrule_combiner
    import flexrule_pkg::*;
#(
    parameter int NUM_UNITS = DEF_UNITS,
    localparam int NUM_GATES = NUM_UNITS / 2,
    localparam int ADDR_W    = $clog2(NUM_UNITS),
    localparam int CNT_W     = $clog2(NUM_GATES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_UNITS-1:0]    unit_bits,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [2:0]              cfg_mask,
    input  logic                    excl_mode,
    output logic [NUM_GATES-1:0]    rule_fire,
    output logic [CNT_W-1:0]        rule_count,
    output logic                    excl_err
);

    link_mask_t [NUM_UNITS-1:0] masks;
    logic [NUM_GATES-1:0]       fire_c;
    logic                       conflict_c;
    logic [CNT_W-1:0]           count_c;

    flexrule_mask_bank #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W)) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (link_mask_t'(cfg_mask)),
        .masks_o (masks)
    );

    flexrule_gate_array #(.NUM_UNITS(NUM_UNITS), .NUM_GATES(NUM_GATES)) gates_i (
        .clk       (clk),
        .rst       (rst),
        .unit_bits (unit_bits),
        .masks     (masks),
        .fire_c    (fire_c)
    );

    flexrule_excl_check #(.NUM_UNITS(NUM_UNITS), .NUM_GATES(NUM_GATES)) excl_i (
        .masks      (masks),
        .excl_mode  (excl_mode),
        .conflict_o (conflict_c)
    );

    always_comb begin
        count_c = '0;
        for (int g = 0; g < NUM_GATES; g++)
            count_c = count_c + CNT_W'(fire_c[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rule_fire  <= '0;
            rule_count <= '0;
            excl_err   <= 1'b0;
        end else begin
            rule_fire  <= fire_c;
            rule_count <= count_c;
            excl_err   <= conflict_c;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rule_fire == '0 && rule_count == '0 && !excl_err)); // R1

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        (rule_count == CNT_W'($countones(rule_fire)))); // R6

    AST_ERR_ONLY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !excl_mode |=> !excl_err); // R7

endmodule

// File: tb/flexrule_combiner_tb.sv
`timescale 1ns/1ps
module flexrule_combiner_tb_top;

    localparam int U  = 16;
    localparam int G  = U / 2;
    localparam int AW = $clog2(U);
    localparam int CW = $clog2(G + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [U-1:0]  unit_bits = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [2:0]    cfg_mask = '0;
    logic          excl_mode = 1'b0;
    logic [G-1:0]  rule_fire;
    logic [CW-1:0] rule_count;
    logic          excl_err;

    always #4 clk = ~clk;

    flexrule_combiner #(.NUM_UNITS(U)) dut_i (
        .clk(clk), .rst(rst), .unit_bits(unit_bits), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .excl_mode(excl_mode),
        .rule_fire(rule_fire), .rule_count(rule_count), .excl_err(excl_err)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    bit [2:0]      m_mask [U];
    bit [G-1:0]    exp_fire = '0;
    int            exp_cnt = 0;
    bit            exp_err = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < U; i++) m_mask[i] = 3'b000;
            exp_fire = '0; exp_cnt = 0; exp_err = 1'b0;
        end else begin
            exp_cnt = 0;
            for (int g = 0; g < G; g++) begin
                int used; bit ok;
                used = 0; ok = 1'b1;
                for (int i = 2*g - 2; i <= 2*g + 3; i++) begin
                    if (i >= 0 && i < U) begin
                        int slot;
                        slot = g - i/2 + 1;
                        if (m_mask[i][slot]) begin
                            used++;
                            ok = ok & unit_bits[i];
                        end
                    end
                end
                exp_fire[g] = (used > 0) && ok;
                if (exp_fire[g]) exp_cnt++;
            end
            exp_err = 1'b0;
            for (int i = 0; i < U; i++) begin
                int n;
                n = 0;
                for (int s = 0; s < 3; s++)
                    if ((i/2 + s - 1) >= 0 && (i/2 + s - 1) < G && m_mask[i][s]) n++;
                if (excl_mode && n > 1) exp_err = 1'b1;
            end
            if (cfg_we) m_mask[cfg_addr] = cfg_mask;
        end
    end

    always @(negedge clk) begin
        if (chk_en && !done) begin
            compared++;
            if (rule_fire !== exp_fire) begin
                mismatched++;
                $display("FAIL %s/R3 rule_fire got %h exp %h", tag, rule_fire, exp_fire);
            end
            compared++;
            if (rule_count !== CW'(exp_cnt)) begin
                mismatched++;
                $display("FAIL %s/R6 rule_count got %0d exp %0d", tag, rule_count, exp_cnt);
            end
            compared++;
            if (excl_err !== exp_err) begin
                mismatched++;
                $display("FAIL %s/R7 excl_err got %b exp %b", tag, excl_err, exp_err);
            end
        end
    end

    task automatic step(input logic [U-1:0] u, input bit we, input int a, input logic [2:0] m);
        unit_bits = u;
        cfg_we    = we;
        cfg_addr  = AW'(a);
        cfg_mask  = m;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [2:0] m);
        step(unit_bits, 1'b1, a, m);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset with all units high
        unit_bits = '1;
        @(posedge clk);
        chk_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step('1, 0, 0, 3'b000);
        step('1, 0, 0, 3'b000);

        // R4: no links enabled, all-ones units stay quiet
        tag = "R4";
        wr(3, 3'b000);
        step('1, 0, 0, 3'b000);
        step(16'hAAAA, 0, 0, 3'b000);

        // R3: gate 2 built from units 4 and 5
        tag = "R3";
        wr(4, 3'b010);
        wr(5, 3'b010);
        step(16'hFFFF, 0, 0, 3'b000);
        step(16'h0010, 0, 0, 3'b000);
        step(16'h0030, 0, 0, 3'b000);
        step(16'hFFCF, 0, 0, 3'b000);
        step(16'h0000, 0, 0, 3'b000);

        // R2: links to gates outside 0..G-1 have no effect
        tag = "R2";
        wr(0, 3'b001);
        step(16'h0000, 0, 0, 3'b000);
        step(16'hFFFE, 0, 0, 3'b000);
        wr(15, 3'b100);
        step(16'h7FFF, 0, 0, 3'b000);
        wr(0, 3'b100);
        step(16'h0001, 0, 0, 3'b000);
        step(16'h0000, 0, 0, 3'b000);

        // R5: write and evaluation on the same edge
        tag = "R5";
        step(16'h0001, 1, 0, 3'b000);
        cfg_we = 1'b0;
        step(16'h0001, 0, 0, 3'b000);
        step(16'h0000, 1, 0, 3'b100);
        cfg_we = 1'b0;
        step(16'h0001, 0, 0, 3'b000);

        // R7: exclusive assignment checking
        tag = "R7";
        excl_mode = 1'b1;
        step(16'h0000, 1, 6, 3'b011);
        cfg_we = 1'b0;
        step(16'h0000, 0, 0, 3'b000);
        wr(6, 3'b010);
        step(16'h0000, 0, 0, 3'b000);
        wr(0, 3'b011);
        step(16'h0000, 0, 0, 3'b000);
        wr(15, 3'b110);
        step(16'h0000, 0, 0, 3'b000);
        wr(14, 3'b101);
        step(16'h0000, 0, 0, 3'b000);
        excl_mode = 1'b0;
        step(16'h0000, 0, 0, 3'b000);
        wr(14, 3'b000);

        // R8: one unit shared by three gates
        tag = "R8";
        wr(6, 3'b111);
        step(16'h0040, 0, 0, 3'b000);
        step(16'hFFFF, 0, 0, 3'b000);
        step(16'hFFBF, 0, 0, 3'b000);
        wr(7, 3'b010);
        step(16'h0040, 0, 0, 3'b000);
        step(16'h00C0, 0, 0, 3'b000);

        // R6: mixed random traffic
        tag = "R6";
        for (int k = 0; k < 400; k++) begin
            excl_mode = 1'($urandom_range(0, 1));
            step(16'($urandom) | 16'($urandom), 1'($urandom_range(0, 2) == 0),
                 $urandom_range(0, U-1), 3'($urandom));
        end
        cfg_we = 1'b0;
        step('0, 0, 0, 3'b000);
        finish_run();
    end

endmodule